// File: doc/BRIEF.md
# Coincidence-Addressed Select Train Generator

This block drives a row of receivers that are addressed by the coincidence of two counter-propagating pulses. The select line enters the row at the far end (receiver n) and the reference line enters at the near end (receiver 1). Both advance one receiver per slot, and one slot is one clock. A receiver fires when a select pulse and the reference pulse reach it in the same slot.

A frame starts when the start strobe is sampled high while the block is idle. The block captures a destination mask, a message word and a mode bit at that edge. It then emits one reference pulse and a serial select train. In the train, each set mask bit produces one select pulse, timed so that it meets the reference at that bit's receiver. Each destination is therefore a signed time offset between the two lines, not a binary address, so any subset of receivers is reached in one frame.

There are two modes, set by the mode input:
- Multicast: the captured message follows the select phase on a separate data line. Only the selected receivers take the message.
- Simulcast: the select train itself is the payload. It carries one bit per receiver, and the data line stays low.

Top module: `cpsel_gen`

## Requirements
- R1: After reset, and whenever the busy output is low, the ref, sel and dat outputs are all low.
- R2: Number the slots of a frame 0, 1, 2, … from the clock cycle that follows the accepting edge. Each frame carries exactly one reference pulse, in slot N_RX−1.
- R3: Number receivers k = 1..N_RX, where mask bit k−1 belongs to receiver k. The select pulse for receiver k is in slot 2(k−1) and is present only if that mask bit is set. Odd slots and slots 2·N_RX and later never carry a select pulse. Because of this placement, each receiver sees a coincidence exactly when its mask bit is set.
- R4: With an odd N_RX, the middle receiver, (N_RX+1)/2, is addressed by a select pulse in the same slot as the reference pulse.
- R5: Any mask value is served in a single frame:
  - an empty mask gives a reference pulse and no select pulse;
  - a full mask gives N_RX select pulses.
- R6: Multicast mode is the mode input at 0. Message bit i appears on dat in slot 2·N_RX+i, for i = 0..N_RX−1. dat is low in all other slots.
- R7: Simulcast mode is the mode input at 1. dat stays low for the whole frame, and the frame has no message phase.
- R8: busy is high for exactly 2·N_RX slots in simulcast mode and exactly 3·N_RX slots in multicast mode, starting in slot 0.
- R9: A start strobe while busy is high is ignored. So are changes to mask, message or mode after the accepting edge. None of them alter the frame in progress.
- R10: A start held high across the end of a frame is accepted at the first edge where busy is low. The new frame then begins with no further idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame start strobe, honoured only while idle |
| simul_i | input | 1 | Mode: 0 multicast, 1 simulcast |
| mask_i | input | N_RX | Destination mask (simulcast: payload bits) |
| msg_i | input | N_RX | Message word for multicast |
| ref_o | output | 1 | Reference line pulse |
| sel_o | output | 1 | Select line pulse train |
| dat_o | output | 1 | Message line |
| busy_o | output | 1 | Frame in progress |

## Verification
The hardest case to reach is the one where a fresh start collides with a frame already in flight. The strobe has to be high, and the mask, message and mode changed, in the middle of a frame. The frame must still finish untouched. Separately, a strobe held across the frame's last slot must be taken with no gap.

The directed tasks reach these cases in two ways:
- They keep start asserted and scramble the captured inputs during the first slots of a frame.
- They chain frames back to back, with start held high.

Every frame is then decoded by a slot model of the line. The model counts coincidences at every receiver, so a misplaced select or reference pulse shows up as a wrong receiver, not just a wrong bit.

// File: rtl/cpsel_pkg.sv
package cpsel_pkg;

  typedef enum logic {
    MODE_MCAST = 1'b0,
    MODE_SCAST = 1'b1
  } cast_mode_e;

  // Slot of the select pulse for zero-based receiver index idx.
  function automatic int unsigned sel_slot(input int unsigned idx);
    return 2 * idx;
  endfunction

  // Slot of the reference pulse for a row of n receivers.
  function automatic int unsigned ref_slot(input int unsigned n);
    return n - 1;
  endfunction

endpackage

// File: rtl/cpsel_pattern.sv
module cpsel_pattern #(
  parameter int N_RX = 7,
  localparam int W2 = 2 * N_RX
) (
  input  logic [N_RX-1:0] mask_i,
  output logic [W2-1:0]   pat_o
);
  import cpsel_pkg::*;

  // Spread the mask over even slots; odd slots stay empty.
  for (genvar k = 0; k < N_RX; k++) begin : g_slot
    assign pat_o[sel_slot(k)]     = mask_i[k];
    assign pat_o[sel_slot(k) + 1] = 1'b0;
  end

endmodule

// File: rtl/cpsel_shreg.sv
module cpsel_shreg #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  output logic         bit_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (load_i) q <= din_i;
    else             q <= q >> 1;
  end

  assign bit_o = q[0];

endmodule

// File: rtl/cpsel_seq.sv
module cpsel_seq #(
  parameter int N_RX = 7,
  localparam int CW = $clog2(3 * N_RX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          simul_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic [CW-1:0] cnt_o,
  output logic          simul_o
);
  localparam logic [CW-1:0] LEN_S = CW'(2 * N_RX);
  localparam logic [CW-1:0] LEN_M = CW'(3 * N_RX);

  logic          active_q;
  logic          simul_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len;
  logic          last;

  assign len      = simul_q ? LEN_S : LEN_M;
  assign last     = (cnt_q == len - 1'b1);
  assign accept_o = start_i && !active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      simul_q  <= 1'b0;
      cnt_q    <= '0;
    end else if (accept_o) begin
      active_q <= 1'b1;
      simul_q  <= simul_i;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (last) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o  = active_q;
  assign cnt_o   = cnt_q;
  assign simul_o = simul_q;

  // R9: once running, the slot count only advances; a new start cannot rewind it
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    (active_q && !last) |=> (active_q && cnt_q == $past(cnt_q) + 1'b1));

  // R8: the slot count stays inside the frame length of the captured mode
  a_r8_len_bound: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (cnt_q < len));

endmodule

// File: rtl/cpsel_gen.sv
module cpsel_gen #(
  parameter int N_RX = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            simul_i,
  input  logic [N_RX-1:0] mask_i,
  input  logic [N_RX-1:0] msg_i,
  output logic            ref_o,
  output logic            sel_o,
  output logic            dat_o,
  output logic            busy_o
);
  import cpsel_pkg::*;

  localparam int W2 = 2 * N_RX;
  localparam int W3 = 3 * N_RX;
  localparam int CW = $clog2(3 * N_RX + 1);
  localparam logic [W2-1:0] REF_PAT = {{(W2-1){1'b0}}, 1'b1} << ref_slot(N_RX);

  logic          accept;
  logic [CW-1:0] cnt;
  logic          simul_q;
  logic [W2-1:0] sel_pat;
  logic [W3-1:0] dat_pat;

  cpsel_seq #(.N_RX(N_RX)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .simul_i  (simul_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .cnt_o    (cnt),
    .simul_o  (simul_q)
  );

  cpsel_pattern #(.N_RX(N_RX)) u_pat (
    .mask_i (mask_i),
    .pat_o  (sel_pat)
  );

  assign dat_pat = (cast_mode_e'(simul_i) == MODE_SCAST) ? '0 : {msg_i, {W2{1'b0}}};

  cpsel_shreg #(.W(W2)) u_ref_sr (
    .clk(clk), .rst(rst), .load_i(accept), .din_i(REF_PAT), .bit_o(ref_o)
  );

  cpsel_shreg #(.W(W2)) u_sel_sr (
    .clk(clk), .rst(rst), .load_i(accept), .din_i(sel_pat), .bit_o(sel_o)
  );

  cpsel_shreg #(.W(W3)) u_dat_sr (
    .clk(clk), .rst(rst), .load_i(accept), .din_i(dat_pat), .bit_o(dat_o)
  );

  // R1: lines are silent outside a frame
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!ref_o && !sel_o && !dat_o));

  // R2: the reference pulse only appears in its fixed slot
  a_r2_ref_slot: assert property (@(posedge clk) disable iff (rst)
    ref_o |-> (busy_o && cnt == CW'(N_RX - 1)));

  // R3: select pulses only in even slots of the select phase
  a_r3_even_slots: assert property (@(posedge clk) disable iff (rst)
    sel_o |-> (!cnt[0] && cnt < CW'(W2)));

  // R6: message bits only in the message phase
  a_r6_dat_phase: assert property (@(posedge clk) disable iff (rst)
    dat_o |-> (cnt >= CW'(W2)));

  // R7: simulcast frames keep the data line low
  a_r7_simul_no_dat: assert property (@(posedge clk) disable iff (rst)
    (busy_o && simul_q) |-> !dat_o);

endmodule

// File: tb/cpsel_gen_tb.sv
module cpsel_gen_tb;
  localparam int N = 7;
  localparam int MAXS = 3 * N + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic simul = 1'b0;
  logic [N-1:0] mask = '0;
  logic [N-1:0] msg = '0;
  logic ref_w, sel_w, dat_w, busy_w;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic sel_r [MAXS];
  logic ref_r [MAXS];
  logic dat_r [MAXS];
  logic bsy_r [MAXS];

  always #10 clk = ~clk;

  cpsel_gen #(.N_RX(N)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .simul_i(simul),
    .mask_i(mask), .msg_i(msg),
    .ref_o(ref_w), .sel_o(sel_w), .dat_o(dat_w), .busy_o(busy_w)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Caller is at a negedge. Runs one frame and checks it against the slot model.
  // perturb: keep start high and scramble inputs during the first slots (R9).
  // hold: leave start high at the end so the next frame follows at once (R10).
  task automatic run_frame(input logic [N-1:0] m, input logic [N-1:0] g,
                           input bit sc, input bit perturb, input bit hold);
    int len;
    int nref;
    int refslot;
    len = sc ? 2 * N : 3 * N;
    start = 1'b1; mask = m; msg = g; simul = sc;
    @(posedge clk); @(negedge clk);
    if (perturb) begin
      mask = ~m; msg = ~g; simul = ~sc;
    end else if (!hold) begin
      start = 1'b0;
    end
    for (int s = 0; s <= len; s++) begin
      sel_r[s] = sel_w; ref_r[s] = ref_w; dat_r[s] = dat_w; bsy_r[s] = busy_w;
      if (perturb && s == 3) begin
        start = 1'b0; mask = m; msg = g; simul = sc;
      end
      if (s == len - 1 && !hold) start = 1'b0;
      if (s < len) begin
        @(posedge clk); @(negedge clk);
      end
    end
    // R8: busy length
    for (int s = 0; s < len; s++) chk(bsy_r[s] == 1'b1, "R8 busy high in frame", int'(bsy_r[s]), 1);
    chk(bsy_r[len] == 1'b0, "R8 busy low after frame", int'(bsy_r[len]), 0);
    // R2: single reference pulse in slot N-1
    nref = 0; refslot = -1;
    for (int s = 0; s <= len; s++) if (ref_r[s]) begin nref++; refslot = s; end
    chk(nref == 1, "R2 reference count", nref, 1);
    chk(refslot == N - 1, "R2 reference slot", refslot, N - 1);
    // R3: odd slots and slots past the select phase carry no select pulse
    for (int s = 0; s <= len; s++)
      if ((s % 2 == 1) || s >= 2 * N) chk(sel_r[s] == 1'b0, "R3 empty slot", s, -1);
    // R3/R5/R9: coincidence per receiver
    for (int j = 1; j <= N; j++) begin
      int hits;
      hits = 0;
      for (int a = 0; a <= len; a++)
        for (int b = 0; b <= len; b++)
          if (sel_r[a] && ref_r[b] && (a + (N - j) == b + (j - 1))) hits++;
      chk(hits == int'(m[j-1]), "R3 coincidence at receiver", hits, int'(m[j-1]));
    end
    // R6/R7: data line
    for (int s = 0; s <= len; s++) begin
      int e;
      e = (!sc && s >= 2 * N && s < 3 * N) ? int'(g[s - 2 * N]) : 0;
      chk(int'(dat_r[s]) == e, sc ? "R7 simulcast data low" : "R6 multicast data", int'(dat_r[s]), e);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk({busy_w, ref_w, sel_w, dat_w} == 4'b0, "R1 reset outputs quiet",
        int'({busy_w, ref_w, sel_w, dat_w}), 0);
  endtask

  task automatic t_middle;  // R4
    run_frame(7'b0001000, 7'h00, 1'b1, 1'b0, 1'b0);
    chk(sel_r[N-1] && ref_r[N-1], "R4 middle receiver same slot", int'(sel_r[N-1]), 1);
  endtask

  task automatic t_subsets;  // R5
    int ns;
    run_frame(7'h00, 7'h00, 1'b1, 1'b0, 1'b0);
    ns = 0; for (int s = 0; s <= 2 * N; s++) if (sel_r[s]) ns++;
    chk(ns == 0, "R5 empty mask no select", ns, 0);
    run_frame(7'h7F, 7'h00, 1'b1, 1'b0, 1'b0);
    ns = 0; for (int s = 0; s <= 2 * N; s++) if (sel_r[s]) ns++;
    chk(ns == N, "R5 full mask select count", ns, N);
    run_frame(7'b1010011, 7'h00, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_multicast;  // R6
    run_frame(7'b0100101, 7'b1100101, 1'b0, 1'b0, 1'b0);
    run_frame(7'b1000001, 7'b0011010, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_simulcast;  // R7
    run_frame(7'b0110110, 7'h7F, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_ignore;  // R9
    run_frame(7'b0010010, 7'b1010101, 1'b0, 1'b1, 1'b0);
    run_frame(7'b1001001, 7'b0110011, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_back_to_back;  // R10
    run_frame(7'b0000110, 7'h00, 1'b1, 1'b0, 1'b1);
    run_frame(7'b1100000, 7'b0101011, 1'b0, 1'b0, 1'b0);
    chk(1'b1, "R10 chained frame busy checked above", 1, 1);
  endtask

  initial begin
    t_reset();
    t_middle();
    t_subsets();
    t_multicast();
    t_simulcast();
    t_ignore();
    t_back_to_back();
    repeat (3) @(negedge clk);
    chk({busy_w, ref_w, sel_w, dat_w} == 4'b0, "R1 idle outputs quiet",
        int'({busy_w, ref_w, sel_w, dat_w}), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule